// File: doc/BRIEF.md
# Two-Cycle Signed/Unsigned Fractional Multiplier

This unit multiplies two 8-bit operands and returns a 16-bit product as a fixed high/low byte pair together with zero and carry flags. A mode select picks how each operand is interpreted: both unsigned, both two's complement, or the first operand two's complement and the second unsigned. A separate bit asks for the fractional (Q-format) form, which shifts the 16-bit product one place to the left so that a product of two 1.7 values lands as a 1.15 value.

A single-cycle start pulse in the idle state latches the operands and the mode. The controller then walks through two named states. ST_IDLE goes to ST_MULT on an accepted start. ST_MULT always goes to ST_FIN, and the result and flag registers load on that edge. ST_FIN always returns to ST_IDLE. The done strobe is high only while the machine is in ST_FIN. A start seen in ST_MULT or ST_FIN is dropped. The high byte, the low byte and both flags keep their values until the next operation finishes.

Top module: `frac_mul_unit`

## Requirements
- R1: After reset, busy_o, done_o, z_o, c_o, res_hi_o and res_lo_o are all 0.
- R2: With mode_i[1:0] = 00, both operands are unsigned. {res_hi_o, res_lo_o} holds the low 16 bits of a×b.
- R3: With mode_i[1:0] = 01, both operands are two's complement. {res_hi_o, res_lo_o} holds the 16-bit two's complement product.
- R4: With mode_i[1:0] = 10, opa_i is two's complement and opb_i is unsigned, and the result is the 16-bit two's complement product. Code 11 behaves like 00.
- R5: With mode_i[2] = 1, the result is the 16-bit product shifted left by one bit. Bit 0 is 0 and the old bit 15 is dropped. With mode_i[2] = 0, no shift is applied.
- R6: c_o equals bit 15 of the product before any fractional shift.
- R7: z_o is 1 exactly when the final 16-bit result, after any shift, is zero.
- R8: If start_i is sampled high in ST_IDLE at edge E0, busy_o is high for the two cycles after E0. done_o is high only in the second of those cycles, and the result and flags are valid in that same cycle.
- R9: A start_i seen while busy_o is high is ignored. It yields no extra done_o and no change of result or flags. Outputs hold their values until the next accepted operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| mode_i | input | 3 | [1:0] signedness (00 uu, 01 ss, 10 su, 11 uu), [2] fractional |
| busy_o | output | 1 | High in ST_MULT and ST_FIN |
| done_o | output | 1 | One-cycle strobe in ST_FIN |
| res_hi_o | output | 8 | Result high byte |
| res_lo_o | output | 8 | Result low byte |
| z_o | output | 1 | Zero flag of the final result |
| c_o | output | 1 | Bit 15 of the unshifted product |

## Verification
The bench aims at the extreme operands. These are −128×−128, where the shift moves a 1 into bit 15, and −128×255 in mixed mode, where a design that sign-extends the second operand would return 0x0080 instead of 0x8080. It also checks that the carry comes from the unshifted product, so a design that takes the carry after the shift would report the wrong C on fractional runs, and that a zero operand gives Z in every mode. Start pulses held through both busy states must not yield a second done strobe or overwrite the result, which would happen if the start pulse were accepted outside the idle state.

// File: rtl/mfu_pkg.sv
package mfu_pkg;
    typedef enum logic [1:0] {
        SGN_UU  = 2'b00,
        SGN_SS  = 2'b01,
        SGN_SU  = 2'b10,
        SGN_ALT = 2'b11
    } sign_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_MULT = 2'b01,
        ST_FIN  = 2'b10
    } mfu_state_e;
endpackage

// File: rtl/mfu_opnd_ext.sv
module mfu_opnd_ext #(
    parameter int W = 8
) (
    input  logic [W-1:0] data_i,
    input  logic         as_signed_i,
    output logic [W:0]   ext_o
);
    always_comb begin
        ext_o = {as_signed_i & data_i[W-1], data_i};
    end
endmodule

// File: rtl/mfu_core.sv
module mfu_core #(
    parameter int W = 8,
    localparam int EW = W + 1,
    localparam int PW = 2 * W
) (
    input  logic [EW-1:0] ea_i,
    input  logic [EW-1:0] eb_i,
    output logic [PW-1:0] raw_o
);
    logic signed [2*EW-1:0] full;

    always_comb begin
        full  = $signed(ea_i) * $signed(eb_i);
        raw_o = full[PW-1:0];
    end
endmodule

// File: rtl/mfu_post.sv
module mfu_post #(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic [PW-1:0] raw_i,
    input  logic          frac_i,
    output logic [PW-1:0] res_o,
    output logic          z_o,
    output logic          c_o
);
    always_comb begin
        res_o = frac_i ? {raw_i[PW-2:0], 1'b0} : raw_i;
        c_o   = raw_i[PW-1];
        z_o   = (res_o == '0);
    end
endmodule

// File: rtl/frac_mul_unit.sv
module frac_mul_unit #(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [2:0]   mode_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] res_hi_o,
    output logic [W-1:0] res_lo_o,
    output logic         z_o,
    output logic         c_o
);
    import mfu_pkg::*;

    mfu_state_e state_q, state_d;
    logic [W-1:0] opnd_q [2];
    sign_mode_e   sgn_q;
    logic         frac_q;
    logic         accept;
    logic         load_res;

    logic [1:0]   is_signed;
    logic [W:0]   ext [2];
    logic [PW-1:0] raw, res_c;
    logic          z_c, c_c;
    logic [PW-1:0] res_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs of the controller
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        load_res = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept  = 1'b1;
                    state_d = ST_MULT;
                end
            end
            ST_MULT: begin
                busy_o   = 1'b1;
                load_res = 1'b1;
                state_d  = ST_FIN;
            end
            ST_FIN: begin
                busy_o  = 1'b1;
                done_o  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opnd_q[0] <= '0;
            opnd_q[1] <= '0;
            sgn_q     <= SGN_UU;
            frac_q    <= 1'b0;
        end else if (accept) begin
            opnd_q[0] <= opa_i;
            opnd_q[1] <= opb_i;
            sgn_q     <= sign_mode_e'(mode_i[1:0]);
            frac_q    <= mode_i[2];
        end
    end

    always_comb begin
        is_signed[0] = (sgn_q == SGN_SS) || (sgn_q == SGN_SU);
        is_signed[1] = (sgn_q == SGN_SS);
    end

    for (genvar gi = 0; gi < 2; gi++) begin : g_ext
        mfu_opnd_ext #(.W(W)) ext_i (
            .data_i     (opnd_q[gi]),
            .as_signed_i(is_signed[gi]),
            .ext_o      (ext[gi])
        );
    end

    mfu_core #(.W(W)) core_i (
        .ea_i (ext[0]),
        .eb_i (ext[1]),
        .raw_o(raw)
    );

    mfu_post #(.W(W)) post_i (
        .raw_i (raw),
        .frac_i(frac_q),
        .res_o (res_c),
        .z_o   (z_c),
        .c_o   (c_c)
    );

    // result pair and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            z_o   <= 1'b0;
            c_o   <= 1'b0;
        end else if (load_res) begin
            res_q <= res_c;
            z_o   <= z_c;
            c_o   <= c_c;
        end
    end

    assign res_hi_o = res_q[PW-1:W];
    assign res_lo_o = res_q[W-1:0];

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o) ##1 done_o); // R8
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(res_hi_o) && $stable(res_lo_o) && $stable(z_o) && $stable(c_o))); // R9
    AST_FRAC_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && frac_q) |-> !res_lo_o[0]); // R5
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (z_o == ({res_hi_o, res_lo_o} == '0))); // R7
endmodule

// File: tb/frac_mul_unit_tb_top.sv
module frac_mul_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] opa_i = '0, opb_i = '0;
    logic [2:0] mode_i = '0;
    logic       busy_o, done_o, z_o, c_o;
    logic [7:0] res_hi_o, res_lo_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    frac_mul_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .opa_i(opa_i), .opb_i(opb_i), .mode_i(mode_i),
        .busy_o(busy_o), .done_o(done_o),
        .res_hi_o(res_hi_o), .res_lo_o(res_lo_o),
        .z_o(z_o), .c_o(c_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int model_raw(input logic [7:0] a, input logic [7:0] b,
                                     input logic [1:0] sgn);
        int av, bv;
        av = (sgn == 2'b01 || sgn == 2'b10) ? int'($signed(a)) : int'(a);
        bv = (sgn == 2'b01) ? int'($signed(b)) : int'(b);
        return (av * bv) & 32'hFFFF;
    endfunction

    // drives one operation and checks timing, result and flags
    task automatic run_op(input string req, input logic [7:0] a, input logic [7:0] b,
                          input logic [2:0] mode);
        int raw, res;
        raw = model_raw(a, b, mode[1:0]);
        res = mode[2] ? ((raw << 1) & 32'hFFFF) : raw;
        @(negedge clk);
        start_i = 1'b1; opa_i = a; opb_i = b; mode_i = mode;
        @(negedge clk);
        start_i = 1'b0;
        chk({"R8 busy first cycle ", req}, int'(busy_o), 1);
        chk({"R8 no early done ", req}, int'(done_o), 0);
        @(negedge clk);
        chk({"R8 done second cycle ", req}, int'(done_o), 1);
        chk({req, " result"}, int'({res_hi_o, res_lo_o}), res);
        chk({"R6 carry ", req}, int'(c_o), (raw >> 15) & 1);
        chk({"R7 zero ", req}, int'(z_o), int'(res == 0));
        @(negedge clk);
        chk({"R8 done drops ", req}, int'(done_o), 0);
        chk({"R8 idle ", req}, int'(busy_o), 0);
    endtask

    task automatic t_reset;
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 result", int'({res_hi_o, res_lo_o}), 0);
        chk("R1 z", int'(z_o), 0);
        chk("R1 c", int'(c_o), 0);
    endtask

    task automatic t_unsigned;
        run_op("R2 uu 255x255", 8'hFF, 8'hFF, 3'b000);
        run_op("R2 uu 12x34", 8'h0C, 8'h22, 3'b000);
    endtask

    task automatic t_signed;
        run_op("R3 ss -128x-128", 8'h80, 8'h80, 3'b001);
        run_op("R3 ss -1x5", 8'hFF, 8'h05, 3'b001);
    endtask

    task automatic t_mixed;
        run_op("R4 su -128x255", 8'h80, 8'hFF, 3'b010);
        run_op("R4 su 3x200", 8'h03, 8'hC8, 3'b010);
        run_op("R4 code11 as uu", 8'hFF, 8'h80, 3'b011);
    endtask

    task automatic t_frac;
        run_op("R5 frac ss -128x-128", 8'h80, 8'h80, 3'b101);
        run_op("R5 frac su -128x255", 8'h80, 8'hFF, 3'b110);
        run_op("R5 frac uu 200x200", 8'hC8, 8'hC8, 3'b100);
        run_op("R5 frac ss 64x-64", 8'h40, 8'hC0, 3'b101);
    endtask

    task automatic t_zero;
        run_op("R7 zero uu", 8'h00, 8'hAB, 3'b000);
        run_op("R7 zero frac ss", 8'h7F, 8'h00, 3'b101);
    endtask

    task automatic t_busy_ignore;
        int exp_res;
        exp_res = 16'h0006;
        @(negedge clk);
        start_i = 1'b1; opa_i = 8'h02; opb_i = 8'h03; mode_i = 3'b000;
        @(negedge clk);
        opa_i = 8'hFF; opb_i = 8'hFF; mode_i = 3'b101;
        @(negedge clk);
        chk("R9 first done", int'(done_o), 1);
        chk("R9 first result", int'({res_hi_o, res_lo_o}), exp_res);
        @(negedge clk);
        start_i = 1'b0;
        chk("R9 no second op", int'(busy_o), 0);
        @(negedge clk);
        chk("R9 no extra done", int'(done_o), 0);
        chk("R9 result held", int'({res_hi_o, res_lo_o}), exp_res);
        chk("R9 flags held", int'({z_o, c_o}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_mixed();
        t_frac();
        t_zero();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule